// File: doc/BRIEF.md
# Per-Packet Transmit Retry and FCS Policy

This block keeps an 8-bit transmit control register with three policy bits: no-retry, no-FCS and pad. When the host writes the final word of a packet into the transmit FIFO with end-of-frame set, the block snapshots the current policy bits. It then queues that snapshot together with the packet. Changing the register afterwards does not alter packets that are already queued.

The transmitter always works on the packet at the head of the queue. For that packet, the block tells the transmitter whether to append a frame check sequence. It also counts collision attempts. After each collision it answers with a one-cycle retry pulse or a one-cycle abort pulse. When the packet completes or is abandoned, it posts a status word with the retry-error flag and the number of attempts made. Backoff timing and the CRC computation belong to other logic.

Top module: `tx_frame_policy`

## Requirements
- R1: After reset the register reads 8'h00. Only bit 7 (no-retry), bit 3 (no-FCS) and bit 0 (pad) store written values. All other bits read as zero.
- R2: A pulse on `soft_rst_i` clears bit 7 and leaves bits 3 and 0 unchanged. It wins over a register write in the same cycle.
- R3: A FIFO write with `fifo_eof_i` high pushes the register value of that cycle into the queue. A FIFO write without end-of-frame pushes nothing. Later register writes do not alter entries already queued.
- R4: The queue holds up to 4 entries and returns them in write order. `q_full_o` is high when it holds 4 entries. A push into a full queue, without a pop in the same cycle, is dropped.
- R5: `fcs_en_o` is 1 when the head entry has pad set or no-FCS clear. It is 0 when only no-FCS is set, and 0 when the queue is empty.
- R6: If the head entry has no-retry set, its first collision gives `abort_o` in the next cycle. It also gives a status with `stat_rtry_err_o`=1 and `stat_attempts_o`=1, and removes the entry.
- R7: If no-retry is clear, collisions 1 to 15 each give a `retry_o` pulse one cycle later. The 16th collision gives `abort_o` and a status with the error flag set and attempts=16.
- R8: `tx_done_i` posts a status one cycle later with the error flag clear and attempts = collisions seen + 1. It removes the entry and clears the counter for the next packet.
- R9: With the queue empty, `tx_coll_i` and `tx_done_i` have no effect. No pulse and no status appear.
- R10: When `tx_coll_i` and `tx_done_i` are high in the same cycle, the collision is handled and the done is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Software reset pulse; clears no-retry |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read value |
| fifo_wr_i | input | 1 | Host write into the transmit FIFO |
| fifo_eof_i | input | 1 | Marks the write as the last word of a packet |
| q_valid_o | output | 1 | At least one packet's policy is queued |
| q_full_o | output | 1 | Policy queue is full |
| tx_coll_i | input | 1 | Collision on the current attempt |
| tx_done_i | input | 1 | Current packet sent successfully |
| fcs_en_o | output | 1 | Append FCS to the head packet |
| retry_o | output | 1 | One-cycle pulse: try the head packet again |
| abort_o | output | 1 | One-cycle pulse: give up on the head packet |
| stat_valid_o | output | 1 | One-cycle pulse: status is valid |
| stat_rtry_err_o | output | 1 | Status: retry error |
| stat_attempts_o | output | 5 | Status: attempts made |

## Verification
The assertions check the following on every cycle:
- retry and abort never coincide;
- an abort always carries an error status;
- a success status never reports zero attempts;
- soft reset always clears the no-retry bit;
- pulses only follow cycles where a packet was queued.

The bench scenarios show the rest: the FCS decision for each bit combination, the queue order and the dropped push into a full queue, the exact attempt count at the 16-attempt limit, and the counter restart between packets.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  localparam int unsigned BIT_NORETRY = 7;
  localparam int unsigned BIT_NOFCS   = 3;
  localparam int unsigned BIT_PAD     = 0;
  localparam logic [7:0]  CFG_MASK    = 8'h89;

  typedef struct packed {
    logic noretry;
    logic nofcs;
    logic pad;
  } tx_ctrl_t;
endpackage

// File: rtl/tfp_ctrl_reg.sv
module tfp_ctrl_reg
  import tfp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output tx_ctrl_t   ctrl_o
);
  logic [7:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (we_i) cfg_q <= wdata_i & CFG_MASK;
      // soft reset wins over a same-cycle write
      if (soft_rst_i) cfg_q[BIT_NORETRY] <= 1'b0;
    end
  end

  assign rdata_o        = cfg_q;
  assign ctrl_o.noretry = cfg_q[BIT_NORETRY];
  assign ctrl_o.nofcs   = cfg_q[BIT_NOFCS];
  assign ctrl_o.pad     = cfg_q[BIT_PAD];
endmodule

// File: rtl/tfp_ctrl_queue.sv
module tfp_ctrl_queue
  import tfp_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  tx_ctrl_t din_i,
  input  logic     pop_i,
  output tx_ctrl_t dout_o,
  output logic     valid_o,
  output logic     full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  tx_ctrl_t         mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign valid_o = (cnt != '0);
  assign full_o  = (cnt == FULL);
  assign do_pop  = pop_i & valid_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tfp_attempt_ctrl.sv
module tfp_attempt_ctrl #(
  parameter int unsigned MAX_ATT = 16,
  parameter int unsigned CNT_W   = $clog2(MAX_ATT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             noretry_i,
  input  logic             coll_i,
  input  logic             done_i,
  output logic             pop_o,
  output logic             retry_o,
  output logic             abort_o,
  output logic             stat_valid_o,
  output logic             stat_err_o,
  output logic [CNT_W-1:0] stat_att_o
);
  logic [CNT_W-1:0] att_q, att_next;
  logic             coll_ev, done_ev, give_up;

  assign att_next = att_q + 1'b1;
  assign coll_ev  = active_i & coll_i;
  assign done_ev  = active_i & done_i & ~coll_i;
  assign give_up  = coll_ev & (noretry_i | (att_next == CNT_W'(MAX_ATT)));
  assign pop_o    = give_up | done_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q        <= '0;
      retry_o      <= 1'b0;
      abort_o      <= 1'b0;
      stat_valid_o <= 1'b0;
      stat_err_o   <= 1'b0;
      stat_att_o   <= '0;
    end else begin
      retry_o      <= coll_ev & ~give_up;
      abort_o      <= give_up;
      stat_valid_o <= pop_o;
      if (pop_o) begin
        stat_err_o <= give_up;
        stat_att_o <= att_next;
        att_q      <= '0;
      end else if (coll_ev) begin
        att_q      <= att_next;
      end
    end
  end
endmodule

// File: rtl/tx_frame_policy.sv
module tx_frame_policy
  import tfp_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH  = 4,
  parameter int unsigned MAX_ATTEMPTS = 16,
  parameter int unsigned ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             fifo_wr_i,
  input  logic             fifo_eof_i,
  output logic             q_valid_o,
  output logic             q_full_o,
  input  logic             tx_coll_i,
  input  logic             tx_done_i,
  output logic             fcs_en_o,
  output logic             retry_o,
  output logic             abort_o,
  output logic             stat_valid_o,
  output logic             stat_rtry_err_o,
  output logic [ATT_W-1:0] stat_attempts_o
);
  tx_ctrl_t live_ctrl, head_ctrl;
  logic     pop;

  tfp_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .ctrl_o     (live_ctrl)
  );

  tfp_ctrl_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_wr_i & fifo_eof_i),
    .din_i   (live_ctrl),
    .pop_i   (pop),
    .dout_o  (head_ctrl),
    .valid_o (q_valid_o),
    .full_o  (q_full_o)
  );

  tfp_attempt_ctrl #(.MAX_ATT(MAX_ATTEMPTS), .CNT_W(ATT_W)) u_att (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (q_valid_o),
    .noretry_i    (head_ctrl.noretry),
    .coll_i       (tx_coll_i),
    .done_i       (tx_done_i),
    .pop_o        (pop),
    .retry_o      (retry_o),
    .abort_o      (abort_o),
    .stat_valid_o (stat_valid_o),
    .stat_err_o   (stat_rtry_err_o),
    .stat_att_o   (stat_attempts_o)
  );

  // pad forces FCS regardless of the disable bit
  assign fcs_en_o = q_valid_o & (head_ctrl.pad | ~head_ctrl.nofcs);
endmodule

// File: rtl/tx_frame_policy_chk.sv
module tx_frame_policy_chk #(
  parameter int unsigned ATT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic [7:0]       cfg_rdata_o,
  input logic             q_valid_o,
  input logic             q_full_o,
  input logic             retry_o,
  input logic             abort_o,
  input logic             stat_valid_o,
  input logic             stat_rtry_err_o,
  input logic [ATT_W-1:0] stat_attempts_o
);
  // R2
  soft_clears_noretry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !cfg_rdata_o[7]);

  // R4
  full_implies_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full_o |-> q_valid_o);

  // R6
  abort_reports_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (stat_valid_o && stat_rtry_err_o));

  // R7
  retry_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (!abort_o && !stat_valid_o));

  // R8
  success_nonzero_att_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && !stat_rtry_err_o) |-> (stat_attempts_o != '0));

  // R9
  events_need_packet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o || stat_valid_o) |-> $past(q_valid_o));
endmodule

bind tx_frame_policy tx_frame_policy_chk #(.ATT_W(ATT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .soft_rst_i      (soft_rst_i),
  .cfg_rdata_o     (cfg_rdata_o),
  .q_valid_o       (q_valid_o),
  .q_full_o        (q_full_o),
  .retry_o         (retry_o),
  .abort_o         (abort_o),
  .stat_valid_o    (stat_valid_o),
  .stat_rtry_err_o (stat_rtry_err_o),
  .stat_attempts_o (stat_attempts_o)
);

// File: tb/tx_frame_policy_bench.sv
`timescale 1ns/1ps
module tx_frame_policy_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       fifo_wr_i = 1'b0;
  logic       fifo_eof_i = 1'b0;
  logic       q_valid_o, q_full_o;
  logic       tx_coll_i = 1'b0;
  logic       tx_done_i = 1'b0;
  logic       fcs_en_o, retry_o, abort_o;
  logic       stat_valid_o, stat_rtry_err_o;
  logic [4:0] stat_attempts_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  tx_frame_policy u_tx_frame_policy (.*);

  // {cfg value, expected fcs_en}
  localparam logic [8:0] FCS_VEC [4] = '{9'h001, 9'h010, 9'h013, 9'h003};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge sample, release at next negedge
  task automatic cyc(input logic we, input logic [7:0] wd, input logic wr, input logic eof,
                     input logic coll, input logic done, input logic srst);
    cfg_we_i = we; cfg_wdata_i = wd; fifo_wr_i = wr; fifo_eof_i = eof;
    tx_coll_i = coll; tx_done_i = done; soft_rst_i = srst;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_we_i = 0; fifo_wr_i = 0; fifo_eof_i = 0; tx_coll_i = 0; tx_done_i = 0; soft_rst_i = 0;
  endtask

  task automatic wr_cfg(input logic [7:0] v); cyc(1, v, 0, 0, 0, 0, 0); endtask
  task automatic push_pkt(); cyc(0, 0, 1, 1, 0, 0, 0); endtask
  task automatic coll(); cyc(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic done(); cyc(0, 0, 0, 0, 0, 1, 0); endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset reg", cfg_rdata_o, 8'h00);
    chk("R9 reset queue", q_valid_o, 0);
    chk("R9 reset status", stat_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    wr_cfg(8'hFF);
    chk("R1 reserved zero", cfg_rdata_o, 8'h89);
    cyc(1, 8'hFF, 0, 0, 0, 0, 1);
    chk("R2 soft reset", cfg_rdata_o, 8'h09);

    // table walk: FCS decision per bit combination
    for (int i = 0; i < 4; i++) begin
      wr_cfg(FCS_VEC[i][8:1]);
      push_pkt();
      chk("R3 push", q_valid_o, 1);
      chk("R5 fcs", fcs_en_o, FCS_VEC[i][0]);
      done();
      chk("R8 stat valid", stat_valid_o, 1);
      chk("R8 err", stat_rtry_err_o, 0);
      chk("R8 attempts", stat_attempts_o, 1);
      chk("R5 empty fcs", fcs_en_o, 0);
    end

    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R3 no eof no push", q_valid_o, 0);

    // order and overflow
    wr_cfg(8'h08); push_pkt();
    wr_cfg(8'h00); push_pkt();
    wr_cfg(8'h09); push_pkt();
    wr_cfg(8'h08); push_pkt();
    chk("R4 full", q_full_o, 1);
    wr_cfg(8'h00); push_pkt();
    chk("R3 head unchanged", fcs_en_o, 0);
    done(); chk("R4 order 2", fcs_en_o, 1);
    done(); chk("R4 order 3", fcs_en_o, 1);
    done(); chk("R4 order 4", fcs_en_o, 0);
    done(); chk("R4 drop when full", q_valid_o, 0);

    // single attempt
    wr_cfg(8'h80); push_pkt();
    coll();
    chk("R6 abort", abort_o, 1);
    chk("R6 no retry", retry_o, 0);
    chk("R6 err", stat_rtry_err_o, 1);
    chk("R6 attempts", stat_attempts_o, 1);
    chk("R6 popped", q_valid_o, 0);

    // sixteen attempts
    wr_cfg(8'h00); push_pkt();
    for (int k = 1; k <= 15; k++) begin
      coll();
      chk("R7 retry", retry_o, 1);
      chk("R7 no abort", abort_o, 0);
    end
    coll();
    chk("R7 abort at 16", abort_o, 1);
    chk("R7 err", stat_rtry_err_o, 1);
    chk("R7 attempts", stat_attempts_o, 16);

    // success after collisions, counter restart
    push_pkt();
    coll(); coll(); coll();
    done();
    chk("R8 attempts after colls", stat_attempts_o, 4);
    chk("R8 err clear", stat_rtry_err_o, 0);
    push_pkt(); done();
    chk("R8 counter cleared", stat_attempts_o, 1);

    // empty queue
    coll();
    chk("R9 no retry", retry_o, 0);
    chk("R9 no abort", abort_o, 0);
    done();
    chk("R9 no status", stat_valid_o, 0);

    // coll and done together
    push_pkt();
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R10 retry", retry_o, 1);
    chk("R10 no status", stat_valid_o, 0);
    done();
    chk("R10 attempts", stat_attempts_o, 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule